// File: doc/BRIEF.md
# Branch Resolution and Fetch Redirect Unit

This unit steers instruction fetch in a five-stage in-order pipeline (fetch F, register read R, execute X, memory M, writeback W) around conditional branches. In its speculating variant it treats every branch as not taken and keeps fetching at the sequential address. The pipeline reports the branch outcome and destination once they are known in the resolution stage. At that point the unit either lets the sequential stream continue with no lost cycle, or loads the fetch address with the destination and kills the younger wrong-path instructions. It kills them by clearing the valid bits it keeps for the front stages, so they never write the register file or memory.

The resolution stage is chosen at build time. Resolving in R keeps the taken-branch cost to one lost slot but puts the compare logic in the register-read stage. Resolving in X loosens that timing and costs two lost slots. A second build-time choice replaces speculation with a cautious scheme. In that scheme, fetching a branch freezes fetch until the branch resolves, so bubbles are inserted instead of wrong-path instructions being fetched.

The unit owns the fetch address register and the valid bits of the R and X slots. It also takes the data-hazard stall from the interlock logic, and a redirect overrides that stall.

Top module: `brp_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fetch_pc_o` equals `RESET_PC`, `stage_valid_o` is 0, and `redirect_o` and `squash_o` are 0.
- R2: With no stall, no redirect and fetch not frozen, `next_pc_o` is `fetch_pc_o + INSTR_BYTES`, and `fetch_pc_o` takes that value on the next clock.
- R3: A resolved branch that is not taken (`br_valid_i`=1, `br_taken_i`=0) raises neither `redirect_o` nor any `squash_o` bit, and fetch continues sequentially with no lost cycle.
- R4: A resolved taken branch raises `redirect_o` in the same cycle, drives `next_pc_o` to `br_target_i`, and `fetch_pc_o` equals that destination on the next clock.
- R5: On a redirect, `squash_o` bit 0 (the instruction in F) is set. Bit 1 (the instruction in R) is set only when the resolution stage is X. Without a redirect, `squash_o` is 0.
- R6: In the cycle after a redirect, the R slot valid bit (`stage_valid_o` bit 0) is 0. When resolving in X, the X slot valid bit (bit 1) is also 0. When resolving in R, bit 1 takes the branch's own R valid bit.
- R7: A stall without a redirect holds `fetch_pc_o` (so `next_pc_o` equals `fetch_pc_o`) and holds the R valid bit, and a bubble (valid 0) enters X.
- R8: When a stall and a taken resolution occur in the same cycle, the redirect wins: the next address is the destination and the stall has no effect on the front stages.
- R9: In the non-speculating build, fetching a branch (`fetch_is_branch_i`=1 while `fetch_valid_o`=1 and no stall) drops `fetch_valid_o` from the next cycle up to and including the cycle the branch resolves. During that time `fetch_pc_o` holds the sequential address.
- R10: In the non-speculating build, a not-taken resolution resumes valid fetch at the sequential address after the branch on the next clock, and a taken one resumes it at the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Data-hazard stall from the interlock logic (freezes F and R) |
| fetch_is_branch_i | input | 1 | Predecode: the instruction being fetched is a conditional branch |
| br_valid_i | input | 1 | A branch in the resolution stage has its outcome this cycle |
| br_taken_i | input | 1 | Branch condition result, 1 = taken |
| br_target_i | input | ADDR_W | Resolved branch destination |
| fetch_pc_o | output | ADDR_W | Address being fetched this cycle |
| next_pc_o | output | ADDR_W | Address to be fetched next cycle |
| fetch_valid_o | output | 1 | The F slot holds a real instruction this cycle |
| redirect_o | output | 1 | Fetch is being redirected to `br_target_i` |
| squash_o | output | 2 | Kill per stage: bit 0 = F, bit 1 = R |
| stage_valid_o | output | 2 | Valid bits of the instructions in R (bit 0) and X (bit 1) |

## Verification
A wrong fetch address register shows on `fetch_pc_o` at the very next clock, either a missed step of `INSTR_BYTES` or a wrong destination. Every cycle is compared against a model, so such an error is reported in the cycle it appears. A wrong valid-tracking state, such as a missed squash or a lost bubble during a stall, shows on `stage_valid_o` one clock after the event. A stuck or early-cleared freeze in the non-speculating build shows as `fetch_valid_o` staying low, or rising while the branch is still in flight, on the first cycle it diverges. All three builds (resolve in R, resolve in X, non-speculating) run on the same stimulus, so a fault that only affects the resolution-depth choice still produces a mismatch on at least one of them.

// File: rtl/brp_pkg.sv
package brp_pkg;

    // Pipeline stage index; the ordering is behaviour (younger = smaller).
    typedef enum logic [1:0] {
        STG_F = 2'd0,
        STG_R = 2'd1,
        STG_X = 2'd2
    } stage_e;

    // Front stages that can hold a wrong-path instruction (F and R).
    localparam int unsigned FRONT_STAGES = 2;
    // Slots whose valid bit this unit tracks (R and X).
    localparam int unsigned TRACK_STAGES = 2;

endpackage

// File: rtl/brp_resolve.sv
module brp_resolve
    import brp_pkg::*;
#(
    parameter stage_e RES_STAGE = STG_X
) (
    input  logic                    br_valid_i,
    input  logic                    br_taken_i,
    input  logic                    stall_i,
    output logic                    redirect_o,
    output logic                    front_hold_o,
    output logic [FRONT_STAGES-1:0] squash_o
);

    localparam int unsigned RES_IDX = int'(RES_STAGE);

    logic redirect;

    always_comb begin
        redirect     = br_valid_i & br_taken_i;
        // A redirect overrides the interlock stall on the front stages.
        front_hold_o = stall_i & ~redirect;
    end

    assign redirect_o = redirect;

    // Only stages younger than the resolution stage carry wrong-path work.
    for (genvar s = 0; s < FRONT_STAGES; s++) begin : g_squash
        if (s < RES_IDX) begin : g_kill
            assign squash_o[s] = redirect;
        end else begin : g_keep
            assign squash_o[s] = 1'b0;
        end
    end

endmodule

// File: rtl/brp_fetch_gate.sv
module brp_fetch_gate #(
    parameter bit SPECULATE = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fetch_is_branch_i,
    input  logic br_valid_i,
    input  logic front_hold_i,
    output logic fetch_valid_o,
    output logic fetch_gate_o
);

    if (SPECULATE) begin : g_spec
        // Never freeze: every fetch slot is real.
        assign fetch_valid_o = 1'b1;
        assign fetch_gate_o  = 1'b0;
    end else begin : g_wait
        typedef struct packed {
            logic waiting;
        } gate_state_t;

        gate_state_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (br_valid_i) begin
                st_d.waiting = 1'b0;
            end else if (!st_q.waiting && fetch_is_branch_i && !front_hold_i) begin
                st_d.waiting = 1'b1;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign fetch_valid_o = ~st_q.waiting;
        assign fetch_gate_o  = st_q.waiting;
    end

endmodule

// File: rtl/brp_pc_gen.sv
module brp_pc_gen #(
    parameter int unsigned     ADDR_W      = 32,
    parameter int unsigned     INSTR_BYTES = 4,
    parameter logic [ADDR_W-1:0] RESET_PC  = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              redirect_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              hold_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] next_pc_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (redirect_i) begin
            st_d.pc = target_i;
        end else if (!hold_i) begin
            st_d.pc = st_q.pc + STEP;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o      = st_q.pc;
    assign next_pc_o = st_d.pc;

endmodule

// File: rtl/brp_valid_track.sv
module brp_valid_track
    import brp_pkg::*;
#(
    parameter stage_e RES_STAGE = STG_X
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    fetch_valid_i,
    input  logic                    redirect_i,
    input  logic                    front_hold_i,
    output logic [TRACK_STAGES-1:0] stage_valid_o
);

    localparam int unsigned RES_IDX = int'(RES_STAGE);

    typedef struct packed {
        logic [TRACK_STAGES-1:0] vld;   // bit k = slot of stage k+1
    } trk_state_t;

    trk_state_t st_d, st_q;

    // Value each slot would receive when the pipe advances.
    logic [TRACK_STAGES-1:0] feed;

    for (genvar k = 0; k < TRACK_STAGES; k++) begin : g_feed
        if (k == 0) begin : g_first
            assign feed[k] = fetch_valid_i;
        end else begin : g_rest
            assign feed[k] = st_q.vld[k-1];
        end
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < TRACK_STAGES; k++) begin
            if (redirect_i && (k + 1 <= RES_IDX)) begin
                // Slot receives a squashed (wrong-path) instruction.
                st_d.vld[k] = 1'b0;
            end else if (front_hold_i) begin
                // R holds its instruction, a bubble goes into X.
                st_d.vld[k] = (k == 0) ? st_q.vld[k] : 1'b0;
            end else begin
                st_d.vld[k] = feed[k];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_valid_o = st_q.vld;

endmodule

// File: rtl/brp_unit.sv
module brp_unit
    import brp_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 32,
    parameter int unsigned       INSTR_BYTES = 4,
    parameter logic [ADDR_W-1:0] RESET_PC    = '0,
    parameter stage_e            RES_STAGE   = STG_X,
    parameter bit                SPECULATE   = 1'b1
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    stall_i,
    input  logic                    fetch_is_branch_i,
    input  logic                    br_valid_i,
    input  logic                    br_taken_i,
    input  logic [ADDR_W-1:0]       br_target_i,
    output logic [ADDR_W-1:0]       fetch_pc_o,
    output logic [ADDR_W-1:0]       next_pc_o,
    output logic                    fetch_valid_o,
    output logic                    redirect_o,
    output logic [FRONT_STAGES-1:0] squash_o,
    output logic [TRACK_STAGES-1:0] stage_valid_o
);

    logic redirect;
    logic front_hold;
    logic fetch_gate;
    logic fetch_valid;

    brp_resolve #(
        .RES_STAGE (RES_STAGE)
    ) u_resolve (
        .br_valid_i   (br_valid_i),
        .br_taken_i   (br_taken_i),
        .stall_i      (stall_i),
        .redirect_o   (redirect),
        .front_hold_o (front_hold),
        .squash_o     (squash_o)
    );

    brp_fetch_gate #(
        .SPECULATE (SPECULATE)
    ) u_gate (
        .clk_i             (clk_i),
        .rst_ni            (rst_ni),
        .fetch_is_branch_i (fetch_is_branch_i),
        .br_valid_i        (br_valid_i),
        .front_hold_i      (front_hold),
        .fetch_valid_o     (fetch_valid),
        .fetch_gate_o      (fetch_gate)
    );

    brp_pc_gen #(
        .ADDR_W      (ADDR_W),
        .INSTR_BYTES (INSTR_BYTES),
        .RESET_PC    (RESET_PC)
    ) u_pc (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .redirect_i (redirect),
        .target_i   (br_target_i),
        .hold_i     (front_hold | fetch_gate),
        .pc_o       (fetch_pc_o),
        .next_pc_o  (next_pc_o)
    );

    brp_valid_track #(
        .RES_STAGE (RES_STAGE)
    ) u_track (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .fetch_valid_i (fetch_valid),
        .redirect_i    (redirect),
        .front_hold_i  (front_hold),
        .stage_valid_o (stage_valid_o)
    );

    assign redirect_o    = redirect;
    assign fetch_valid_o = fetch_valid;

endmodule

// File: rtl/brp_unit_chk.sv
module brp_unit_chk #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned INSTR_BYTES = 4,
    parameter bit          SPECULATE   = 1'b1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              stall_i,
    input logic              fetch_is_branch_i,
    input logic              br_valid_i,
    input logic              br_taken_i,
    input logic [ADDR_W-1:0] br_target_i,
    input logic [ADDR_W-1:0] fetch_pc_o,
    input logic              fetch_valid_o,
    input logic              redirect_o,
    input logic [1:0]        squash_o,
    input logic [1:0]        stage_valid_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    // R2
    seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!redirect_o && !stall_i && fetch_valid_o && !br_valid_i)
        |=> fetch_pc_o == $past(fetch_pc_o) + STEP);

    // R4
    redirect_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |=> fetch_pc_o == $past(br_target_i));

    // R5
    squash_needs_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(br_valid_i && br_taken_i) |-> squash_o == 2'b00);

    // R6
    squash_clears_r_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |=> !stage_valid_o[0]);

    // R7
    stall_holds_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_i && !redirect_o) |=> $stable(fetch_pc_o) && !stage_valid_o[1]);

    // R9
    freeze_after_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!SPECULATE && fetch_valid_o && fetch_is_branch_i && !stall_i && !br_valid_i)
        |=> !fetch_valid_o);

endmodule

bind brp_unit brp_unit_chk #(
    .ADDR_W      (ADDR_W),
    .INSTR_BYTES (INSTR_BYTES),
    .SPECULATE   (SPECULATE)
) u_chk (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .stall_i           (stall_i),
    .fetch_is_branch_i (fetch_is_branch_i),
    .br_valid_i        (br_valid_i),
    .br_taken_i        (br_taken_i),
    .br_target_i       (br_target_i),
    .fetch_pc_o        (fetch_pc_o),
    .fetch_valid_o     (fetch_valid_o),
    .redirect_o        (redirect_o),
    .squash_o          (squash_o),
    .stage_valid_o     (stage_valid_o)
);

// File: tb/tb_brp_unit.sv
module tb_brp_unit;
    import brp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NDUT = 3;

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] nx;
        logic        fv;
        logic        rd;
        logic [1:0]  sq;
        logic [1:0]  sv;
    } obs_t;

    typedef struct {
        obs_t  e [NDUT];
        string tag;
    } rec_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall = 1'b0, fib = 1'b0, bv = 1'b0, bt = 1'b0;
    logic [31:0] tgt = '0;

    logic [31:0] pc_o [NDUT];
    logic [31:0] nx_o [NDUT];
    logic        fv_o [NDUT];
    logic        rd_o [NDUT];
    logic [1:0]  sq_o [NDUT];
    logic [1:0]  sv_o [NDUT];

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    rec_t q[$];

    // Model configuration: resolution depth and speculation, one per DUT.
    int res_c  [NDUT] = '{2, 1, 2};
    bit spec_c [NDUT] = '{1'b1, 1'b1, 1'b0};

    logic [31:0] mpc [NDUT];
    logic        mv1 [NDUT];
    logic        mv2 [NDUT];
    logic        mwait [NDUT];

    always #(CLK_PERIOD/2) clk = ~clk;

    brp_unit #(.RES_STAGE(STG_X), .SPECULATE(1'b1)) dut (
        .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .fetch_is_branch_i(fib),
        .br_valid_i(bv), .br_taken_i(bt), .br_target_i(tgt),
        .fetch_pc_o(pc_o[0]), .next_pc_o(nx_o[0]), .fetch_valid_o(fv_o[0]),
        .redirect_o(rd_o[0]), .squash_o(sq_o[0]), .stage_valid_o(sv_o[0]));

    brp_unit #(.RES_STAGE(STG_R), .SPECULATE(1'b1)) dut_r (
        .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .fetch_is_branch_i(fib),
        .br_valid_i(bv), .br_taken_i(bt), .br_target_i(tgt),
        .fetch_pc_o(pc_o[1]), .next_pc_o(nx_o[1]), .fetch_valid_o(fv_o[1]),
        .redirect_o(rd_o[1]), .squash_o(sq_o[1]), .stage_valid_o(sv_o[1]));

    brp_unit #(.RES_STAGE(STG_X), .SPECULATE(1'b0)) dut_c (
        .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .fetch_is_branch_i(fib),
        .br_valid_i(bv), .br_taken_i(bt), .br_target_i(tgt),
        .fetch_pc_o(pc_o[2]), .next_pc_o(nx_o[2]), .fetch_valid_o(fv_o[2]),
        .redirect_o(rd_o[2]), .squash_o(sq_o[2]), .stage_valid_o(sv_o[2]));

    // Driver: called at a falling edge; drives one cycle, pushes expectations,
    // advances the model, then waits for the next falling edge.
    task automatic drive(input string tag, input logic s, input logic f,
                         input logic v, input logic t, input logic [31:0] d);
        rec_t r;
        stall = s; fib = f; bv = v; bt = t; tgt = d;
        r.tag = tag;
        for (int i = 0; i < NDUT; i++) begin
            logic fvx, rdx, hold, gate;
            logic [31:0] nxx;
            fvx  = spec_c[i] ? 1'b1 : !mwait[i];
            rdx  = v && t;
            hold = s && !rdx;
            gate = !spec_c[i] && mwait[i];
            nxx  = rdx ? d : ((hold || gate) ? mpc[i] : mpc[i] + 32'd4);
            r.e[i].pc = mpc[i];
            r.e[i].nx = nxx;
            r.e[i].fv = fvx;
            r.e[i].rd = rdx;
            r.e[i].sq = {rdx && (res_c[i] > 1), rdx};
            r.e[i].sv = {mv2[i], mv1[i]};
            // state update
            if (!spec_c[i]) begin
                if (v) mwait[i] = 1'b0;
                else if (fvx && f && !hold) mwait[i] = 1'b1;
            end
            begin
                logic n1, n2;
                n1 = rdx ? 1'b0 : (hold ? mv1[i] : fvx);
                n2 = rdx ? ((res_c[i] == 1) ? mv1[i] : 1'b0) : (hold ? 1'b0 : mv1[i]);
                mv1[i] = n1;
                mv2[i] = n2;
            end
            mpc[i] = nxx;
        end
        q.push_back(r);
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input int n);
        for (int k = 0; k < n; k++) drive(tag, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    endtask

    // Monitor: compares each DUT a quarter period after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (q.size() > 0) begin
                rec_t r;
                r = q.pop_front();
                for (int i = 0; i < NDUT; i++) begin
                    obs_t a;
                    a = '{pc: pc_o[i], nx: nx_o[i], fv: fv_o[i], rd: rd_o[i],
                          sq: sq_o[i], sv: sv_o[i]};
                    checks++;
                    if (a !== r.e[i]) begin
                        fails++;
                        $display("FAIL %s dut%0d actual pc=%h nx=%h fv=%b rd=%b sq=%b sv=%b expected pc=%h nx=%h fv=%b rd=%b sq=%b sv=%b",
                                 r.tag, i, a.pc, a.nx, a.fv, a.rd, a.sq, a.sv,
                                 r.e[i].pc, r.e[i].nx, r.e[i].fv, r.e[i].rd, r.e[i].sq, r.e[i].sv);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NDUT; i++) begin
            mpc[i] = 32'h0; mv1[i] = 1'b0; mv2[i] = 1'b0; mwait[i] = 1'b0;
        end
        repeat (2) @(negedge clk);
        #(CLK_PERIOD/4);
        // R1: state held in reset
        for (int i = 0; i < NDUT; i++) begin
            checks++;
            if (pc_o[i] !== 32'h0 || sv_o[i] !== 2'b00 || rd_o[i] !== 1'b0 || sq_o[i] !== 2'b00) begin
                fails++;
                $display("FAIL R1 dut%0d actual pc=%h sv=%b rd=%b sq=%b expected pc=0 sv=00 rd=0 sq=00",
                         i, pc_o[i], sv_o[i], rd_o[i], sq_o[i]);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;
        drive("R1", 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        idle("R2", 4);
        drive("R3", 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0800);
        idle("R3", 2);
        drive("R4", 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0100);
        idle("R6", 3);
        drive("R5", 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0140);
        idle("R6", 2);
        drive("R7", 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        drive("R7", 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        idle("R7", 2);
        drive("R8", 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_0200);
        idle("R8", 3);
        drive("R9", 1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
        idle("R9", 2);
        drive("R10", 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0900);
        idle("R10", 3);
        drive("R9", 1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
        drive("R9", 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        idle("R9", 1);
        drive("R10", 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0300);
        idle("R10", 3);
        idle("R2", 2);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule